// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block encodes and decodes the 64-bit data path of a shared, active-low system bus that moves several data transfers per bus clock. The word is handled as four independent 16-bit lanes. On the transmit side, each lane is compared with the wire levels it drove on the previous transfer. If sending the lane as is would toggle more than half of its wires, the block sends the complemented lane and asserts that lane's inversion flag. This keeps simultaneous switching on any lane to at most eight wires per transfer.

The transmit side registers the encoded wire data, the four inversion flags and an active-low data-ready indication in the same cycle. The wire reference moves forward with every accepted transfer, so back-to-back transfers are each measured against the one immediately before them. The receive side is purely combinational. It uses each lane's flag to undo the inversion and removes the active-low convention, giving back the true data.

Top module: `dbi_codec`

## Requirements
- R1: Lane g (g = 0..3) covers data bits [16g+15:16g], and flag bit g belongs to that lane only. The other lanes never affect its decision or its decoding.
- R2: While reset is held low, and after it is released, the transmit wires are all ones, all four flags are high (deasserted) and the data-ready output is high.
- R3: For an accepted transfer, the plain wire value of a lane is the complement of its data. The lane is inverted only if this plain value differs from the lane's previously driven wire value in 9 or more of its 16 bits. Exactly 8 differing bits leaves the lane plain.
- R4: An inverted lane drives its true data on the wires with its flag low (0). A plain lane drives the complemented data with its flag high (1).
- R5: The wires, flags and data-ready output all change on the clock edge that samples tx_valid high, and appear together one cycle after the inputs. Data-ready is low for exactly the cycles that follow an accepted transfer.
- R6: When tx_valid is low, changes on tx_data do not affect the wires or flags, which hold their last values, and data-ready is high.
- R7: The reference for the next transfer is the wire value actually driven, after any inversion. It advances on every accepted transfer, including back-to-back ones.
- R8: The receiver outputs, for each lane, the complement of the wire bits when that lane's flag is high, and the wire bits unchanged when the flag is low (0).

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per transfer |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transfer request for tx_data this cycle |
| tx_data | input | 64 | True data to send |
| tx_wire_n | output | 64 | Encoded active-low wire data |
| tx_flag_n | output | 4 | Active-low inversion flags, one per lane |
| tx_rdy_n | output | 1 | Active-low data-ready, aligned with the wires |
| rx_wire_n | input | 64 | Received active-low wire data |
| rx_flag_n | input | 4 | Received active-low inversion flags |
| rx_data | output | 64 | Recovered true data |

## Verification
The only internal state is the driven-wire reference. If it is wrong, the error shows in the next accepted transfer. A lane's flag then flips against the count taken from the visible wires, or the lane toggles more than eight wires relative to what was just on the bus. The bench keeps its own copy of the reference and compares every transfer in the cycle it is driven. Chained back-to-back words, and a pair built so that a reference taken before inversion would choose the opposite flag, catch a stale or wrongly taken reference in one or two transfers.

// File: rtl/dbi_codec.sv
module dbi_codec #(
  parameter int GROUPS = 4,
  parameter int GW     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_valid,
  input  logic [GROUPS*GW-1:0] tx_data,
  output logic [GROUPS*GW-1:0] tx_wire_n,
  output logic [GROUPS-1:0]    tx_flag_n,
  output logic                 tx_rdy_n,
  input  logic [GROUPS*GW-1:0] rx_wire_n,
  input  logic [GROUPS-1:0]    rx_flag_n,
  output logic [GROUPS*GW-1:0] rx_data
);
  localparam int W    = GROUPS * GW;
  localparam int HALF = GW / 2;

  function automatic int unsigned ones(input logic [GW-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < GW; i++) n += int'(v[i]);
    return n;
  endfunction

  logic [W-1:0]      wire_q, wire_d;
  logic [GROUPS-1:0] flag_q, flag_d;
  logic              rdy_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    logic [GW-1:0] plain;
    logic          inv;
    assign plain = ~tx_data[g*GW +: GW];
    assign inv   = ones(plain ^ wire_q[g*GW +: GW]) > HALF;
    assign wire_d[g*GW +: GW] = inv ? ~plain : plain;
    assign flag_d[g] = ~inv;
    assign rx_data[g*GW +: GW] = ~(rx_wire_n[g*GW +: GW] ^ {GW{~rx_flag_n[g]}});

    a_r3_lane_swing: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_rdy_n |-> $countones(tx_wire_n[g*GW +: GW] ^ $past(tx_wire_n[g*GW +: GW])) <= HALF);

    a_r3_flag_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_rdy_n |-> ((!tx_flag_n[g]) ==
        ($countones(~$past(tx_data[g*GW +: GW]) ^ $past(tx_wire_n[g*GW +: GW])) > HALF)));

    a_r4_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_rdy_n |-> ((tx_wire_n[g*GW +: GW] ^ {GW{~tx_flag_n[g]}}) == ~$past(tx_data[g*GW +: GW])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wire_q <= '1;
      flag_q <= '1;
      rdy_q  <= 1'b1;
    end else begin
      rdy_q <= ~tx_valid;
      if (tx_valid) begin
        wire_q <= wire_d;
        flag_q <= flag_d;
      end
    end
  end

  assign tx_wire_n = wire_q;
  assign tx_flag_n = flag_q;
  assign tx_rdy_n  = rdy_q;

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rdy_n |-> ($stable(tx_wire_n) && $stable(tx_flag_n)));

  a_r5_ready_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tx_rdy_n == !$past(tx_valid)));
endmodule

// File: tb/dbi_codec_tb_top.sv
module dbi_codec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0;
  logic [63:0] tx_data = '0;
  logic [63:0] tx_wire_n;
  logic [3:0]  tx_flag_n;
  logic        tx_rdy_n;
  logic [63:0] rx_wire_n = '1;
  logic [3:0]  rx_flag_n = '1;
  logic [63:0] rx_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] ref_wire = '1;
  logic [3:0]  ref_flag = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbi_codec dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_wire_n(tx_wire_n), .tx_flag_n(tx_flag_n), .tx_rdy_n(tx_rdy_n),
    .rx_wire_n(rx_wire_n), .rx_flag_n(rx_flag_n), .rx_data(rx_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

  // model per R3/R4/R7: update the reference from the expected driven wires
  task automatic model(input logic [63:0] d);
    for (int g = 0; g < 4; g++) begin
      logic [15:0] plain = ~d[g*16 +: 16];
      if (popc(plain ^ ref_wire[g*16 +: 16]) > 8) begin
        ref_wire[g*16 +: 16] = ~plain;
        ref_flag[g] = 1'b0;
      end else begin
        ref_wire[g*16 +: 16] = plain;
        ref_flag[g] = 1'b1;
      end
    end
  endtask

  task automatic send(input logic [63:0] d);
    tx_valid = 1'b1;
    tx_data  = d;
    model(d);
    @(negedge clk);
    check("R3/R4 wires", tx_wire_n, ref_wire);
    check("R3/R4 flags", {60'd0, tx_flag_n}, {60'd0, ref_flag});
    check("R5 ready", {63'd0, tx_rdy_n}, 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tx_valid = 1'b1;
    tx_data = 64'h1234_5678_9abc_def0;
    repeat (2) @(negedge clk);
    check("R2 wires in reset", tx_wire_n, '1);
    check("R2 flags in reset", {60'd0, tx_flag_n}, 64'hF);
    check("R2 ready in reset", {63'd0, tx_rdy_n}, 64'd1);
    tx_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 wires after reset", tx_wire_n, '1);
    check("R2 ready after reset", {63'd0, tx_rdy_n}, 64'd1);
    ref_wire = '1;
    ref_flag = '1;
  endtask

  task automatic t_basic();
    send(64'h0);
    check("R4 plain zero", tx_wire_n, '1);
    send('1);
    check("R4 full swing inverts", {60'd0, tx_flag_n}, 64'h0);
    check("R4 inverted lanes carry true data", tx_wire_n, '1);
  endtask

  task automatic t_threshold();
    send(64'h0);
    // lane0: 8 changes, lane1: 9, lane2: 0, lane3: 16
    send(64'hFFFF_0000_01FF_00FF);
    check("R3 boundary flags", {60'd0, tx_flag_n}, 64'h5);
    check("R1 lane mapping", tx_wire_n, 64'hFFFF_FFFF_01FF_FF00);
  endtask

  task automatic t_reference();
    send(64'h0);
    send(64'h0000_0000_0000_FFFF);
    check("R7 lane0 inverted first", {63'd0, tx_flag_n[0]}, 64'd0);
    send(64'h0);
    check("R7 reference is driven wire", {63'd0, tx_flag_n[0]}, 64'd1);
  endtask

  task automatic t_chain();
    logic [63:0] lf = 64'hACE1_3579_BDF0_2468;
    for (int i = 0; i < 24; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      send(lf ^ {16{i[3:0]}});
    end
  endtask

  task automatic t_idle();
    logic [63:0] w;
    logic [3:0]  f;
    send(64'hDEAD_BEEF_0F0F_A5A5);
    w = tx_wire_n;
    f = tx_flag_n;
    tx_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tx_data = ~tx_data ^ 64'h0123_4567_89AB_CDEF;
      @(negedge clk);
      check("R6 wires held", tx_wire_n, w);
      check("R6 flags held", {60'd0, tx_flag_n}, {60'd0, f});
      check("R6 ready high", {63'd0, tx_rdy_n}, 64'd1);
    end
    send(64'h0);
  endtask

  task automatic t_decode();
    rx_wire_n = 64'h0123_4567_89AB_CDEF;
    rx_flag_n = 4'hF;
    #1 check("R8 plain lanes", rx_data, ~64'h0123_4567_89AB_CDEF);
    rx_flag_n = 4'h0;
    #1 check("R8 inverted lanes", rx_data, 64'h0123_4567_89AB_CDEF);
    rx_flag_n = 4'b1010;
    #1 check("R1 per-lane decode", rx_data, 64'hFEDC_4567_7654_CDEF);
    rx_wire_n = tx_wire_n;
    rx_flag_n = tx_flag_n;
    #1 check("R8 loopback", rx_data, 64'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_threshold();
    t_reference();
    t_chain();
    t_idle();
    t_decode();
    tx_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule